// File: doc/BRIEF.md
# Video/Audio Bit Merger with Column Padding

This block folds two serial bit streams, one carrying video and one carrying audio, into a single payload bit stream. Bits are taken in groups: a fixed run of video bits, then a fixed run of audio bits, then again. With the default group shape of 8 video and 4 audio bits, M video bits yield M/8 groups and 3M/2 merged bits. The merged stream is cut into columns of `col_len_i` bits so that it can be written into a resource grid one column at a time.

The end of the video material is flagged by `vid_last_i` on the final video bit. The group holding that bit is completed with its audio bits. If the merged length is not a whole number of columns, the short final column is filled out with a structured pattern. The pattern is four runs of ones, zeros, ones and zeros, and it is used in place of plain zeros. The output raises `out_last_o` on the final bit of that column. All three ports use valid/ready handshakes. The block adds no buffering, so one output bit moves per cycle whenever the chosen source and the sink are both ready.

Top module: `av_bit_merger`

## Requirements
- R1: Within each group the output carries exactly 8 video bits, in arrival order, followed by exactly 4 audio bits, in arrival order. No audio bit is accepted while a video slot is open, and no video bit is accepted while an audio slot is open.
- R2: A frame ends with the audio bits of the group in which `vid_last_i` was seen on an accepted video bit, so G groups give 12*G merged bits. The video bit count is a multiple of 8.
- R3: The output of one frame is the smallest multiple of `col_len_i` (N, at least 1, held stable through the frame) that is at least 12*G bits. When 12*G is a multiple of N, no padding bit is sent.
- R4: The R padding bits of a short last column form four parts. Parts one to three hold floor(R/4) bits each, and part four holds floor(R/4) plus R mod 4 bits.
- R5: The four padding parts carry the values 1, 0, 1, 0 in that order, so a span of fewer than 4 bits is all zeros.
- R6: When the audio source is not valid in an audio slot, the output shows no valid bit and no further video bit is accepted. No filler is produced.
- R7: `out_last_o` is high on the final output bit of each frame and low on every other valid output bit.
- R8: While `out_ready_i` is low, neither input is accepted, and a valid output holds its bit until it is taken. No bit is lost or repeated.
- R9: After reset, with no input valid, `out_valid_o`, `out_last_o` and `aud_ready_o` are low, and the first slot accepts video.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vid_valid_i | input | 1 | Video bit available |
| vid_bit_i | input | 1 | Video bit |
| vid_last_i | input | 1 | Marks the final video bit of the frame |
| vid_ready_o | output | 1 | Video bit accepted this cycle when valid |
| aud_valid_i | input | 1 | Audio bit available |
| aud_bit_i | input | 1 | Audio bit |
| aud_ready_o | output | 1 | Audio bit accepted this cycle when valid |
| col_len_i | input | LEN_W | Column length N in bits, at least 1 |
| out_valid_o | output | 1 | Merged bit available |
| out_bit_o | output | 1 | Merged or padding bit |
| out_last_o | output | 1 | Final bit of the frame |
| out_ready_i | input | 1 | Sink takes the bit this cycle |

## Verification
The bench sweeps every column length from 1 to 13 against frames of one to four groups. This covers exact fits with no padding, spans shorter than four bits that must be all zeros, and spans with a remainder that must land in the last part. A design that split the span wrongly would shift the one/zero boundaries, and one that padded with zeros would corrupt the first part. Half the runs toggle the sink's ready signal. A design that let an input slip through during backpressure would drop or duplicate merged bits. One frame starves the audio source, so a design that inserted filler or ran ahead on video would show extra output bits. The position of the end-of-frame marker is checked on every bit, which catches a marker placed on the last data bit rather than on the last padding bit.

// File: rtl/av_merge_pkg.sv
package av_merge_pkg;
  localparam int VID_PER_GRP = 8;
  localparam int AUD_PER_GRP = 4;

  typedef enum logic {
    PH_MERGE = 1'b0,
    PH_PAD   = 1'b1
  } phase_e;
endpackage

// File: rtl/av_grp_sel.sv
module av_grp_sel #(
  parameter int VID_N = 8,
  parameter int AUD_N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic sel_aud_o,
  output logic grp_end_o
);
  localparam int GRP = VID_N + AUD_N;
  localparam int CW  = $clog2(GRP);

  logic [CW-1:0] cnt_q;

  assign sel_aud_o = cnt_q >= CW'(VID_N);
  assign grp_end_o = cnt_q == CW'(GRP - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (adv_i)     cnt_q <= grp_end_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/av_chunk_cnt.sv
module av_chunk_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] col_len_i,
  output logic [LEN_W-1:0] pos_o,
  output logic             chunk_end_o
);
  logic [LEN_W-1:0] pos_q;

  assign pos_o       = pos_q;
  assign chunk_end_o = pos_q == col_len_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (adv_i) pos_q <= chunk_end_o ? '0 : pos_q + 1'b1;
  end
endmodule

// File: rtl/av_pad_gen.sv
module av_pad_gen #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic             adv_i,
  output logic             bit_o
);
  logic [LEN_W-1:0] q_q, p_q;
  logic [LEN_W:0]   q1, q2, q3, pe;

  // part edges at q, 2q, 3q; last part absorbs the remainder
  always_comb begin
    q1    = {1'b0, q_q};
    q2    = q1 << 1;
    q3    = q2 + q1;
    pe    = {1'b0, p_q};
    bit_o = (pe < q1) | ((pe >= q2) & (pe < q3));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
      p_q <= '0;
    end else if (start_i) begin
      q_q <= rem_i >> 2;
      p_q <= '0;
    end else if (adv_i) begin
      p_q <= p_q + 1'b1;
    end
  end
endmodule

// File: rtl/av_bit_merger.sv
module av_bit_merger
  import av_merge_pkg::*;
#(
  parameter int VID_N = VID_PER_GRP,
  parameter int AUD_N = AUD_PER_GRP,
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vid_valid_i,
  input  logic             vid_bit_i,
  input  logic             vid_last_i,
  output logic             vid_ready_o,
  input  logic             aud_valid_i,
  input  logic             aud_bit_i,
  output logic             aud_ready_o,
  input  logic [LEN_W-1:0] col_len_i,
  output logic             out_valid_o,
  output logic             out_bit_o,
  output logic             out_last_o,
  input  logic             out_ready_i
);
  phase_e           phase_q;
  logic             end_seen_q;
  logic             sel_aud, grp_end, chunk_end, pad_bit;
  logic             in_merge, fire, frame_end, pad_start;
  logic [LEN_W-1:0] pos, pad_rem;

  assign in_merge = phase_q == PH_MERGE;

  always_comb begin
    if (in_merge) begin
      out_valid_o = sel_aud ? aud_valid_i : vid_valid_i;
      out_bit_o   = sel_aud ? aud_bit_i : vid_bit_i;
    end else begin
      out_valid_o = 1'b1;
      out_bit_o   = pad_bit;
    end
    vid_ready_o = in_merge & ~sel_aud & out_ready_i;
    aud_ready_o = in_merge & sel_aud & out_ready_i;
    fire        = out_valid_o & out_ready_i;
    frame_end   = in_merge & fire & grp_end & end_seen_q;
    pad_start   = frame_end & ~chunk_end;
    pad_rem     = col_len_i - 1'b1 - pos;
    out_last_o  = out_valid_o & chunk_end &
                  (in_merge ? (grp_end & end_seen_q) : 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_MERGE;
      end_seen_q <= 1'b0;
    end else begin
      if (in_merge && pad_start)               phase_q <= PH_PAD;
      else if (!in_merge && fire && chunk_end) phase_q <= PH_MERGE;
      if (frame_end)                           end_seen_q <= 1'b0;
      else if (vid_valid_i && vid_ready_o && vid_last_i) end_seen_q <= 1'b1;
    end
  end

  av_grp_sel #(.VID_N(VID_N), .AUD_N(AUD_N)) grp_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (in_merge & fire),
    .sel_aud_o (sel_aud),
    .grp_end_o (grp_end)
  );

  av_chunk_cnt #(.LEN_W(LEN_W)) chunk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (fire),
    .col_len_i   (col_len_i),
    .pos_o       (pos),
    .chunk_end_o (chunk_end)
  );

  av_pad_gen #(.LEN_W(LEN_W)) pad_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (pad_start),
    .rem_i   (pad_rem),
    .adv_i   (~in_merge & fire),
    .bit_o   (pad_bit)
  );
endmodule

// File: rtl/av_merger_chk.sv
module av_merger_chk #(
  parameter int VID_N = 8,
  parameter int AUD_N = 4,
  parameter int LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vid_valid_i,
  input logic             vid_bit_i,
  input logic             vid_last_i,
  input logic             vid_ready_o,
  input logic             aud_valid_i,
  input logic             aud_bit_i,
  input logic             aud_ready_o,
  input logic [LEN_W-1:0] col_len_i,
  input logic             out_valid_o,
  input logic             out_bit_o,
  input logic             out_last_o,
  input logic             out_ready_i
);
  localparam int GRP = VID_N + AUD_N;

  logic [7:0]       gcnt_q;
  logic [LEN_W-1:0] ocnt_q;
  logic             vid_hs, aud_hs, out_hs;

  assign vid_hs = vid_valid_i & vid_ready_o;
  assign aud_hs = aud_valid_i & aud_ready_o;
  assign out_hs = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gcnt_q <= '0;
      ocnt_q <= '0;
    end else begin
      if (vid_hs || aud_hs) gcnt_q <= (gcnt_q == 8'(GRP - 1)) ? '0 : gcnt_q + 1'b1;
      if (out_hs) ocnt_q <= (ocnt_q == col_len_i - 1'b1) ? '0 : ocnt_q + 1'b1;
    end
  end

  assert_vid_slot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_hs |-> gcnt_q < 8'(VID_N));

  assert_aud_slot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aud_hs |-> gcnt_q >= 8'(VID_N));

  assert_last_on_col_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o) |-> ocnt_q == col_len_i - 1'b1);

  assert_no_take_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_ready_i |-> (!vid_ready_o && !aud_ready_o));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_bit_o)));
endmodule

bind av_bit_merger av_merger_chk #(.VID_N(VID_N), .AUD_N(AUD_N), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/av_bit_merger_tb_top.sv
`timescale 1ns/1ps
module av_bit_merger_tb_top;
  localparam int LEN_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic vid_valid_i = 1'b0, vid_bit_i = 1'b0, vid_last_i = 1'b0, vid_ready_o;
  logic aud_valid_i = 1'b0, aud_bit_i = 1'b0, aud_ready_o;
  logic [LEN_W-1:0] col_len_i = 8'd4;
  logic out_valid_o, out_bit_o, out_last_o;
  logic out_ready_i = 1'b1;

  int errors = 0, checks = 0, gcyc = 0;
  logic [7:0] lfsr = 8'hA5;
  bit exp_q [0:255];

  always #2.5 clk_i = ~clk_i;

  av_bit_merger #(.LEN_W(LEN_W)) dut_i (.*);

  function automatic bit vbit(int k);
    return 1'(((k * 3) ^ (k >> 2) ^ 5) & 1);
  endfunction
  function automatic bit abit(int k);
    return 1'(((k * 5) ^ (k >> 1) ^ 2) & 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    gcyc++;
    if (gcyc > 150000) begin
      check(1'b0, "watchdog", gcyc, 150000);
      finish_run();
    end
  end

  task automatic run_frame(int g, int n, bit bp, int aud_block);
    int m, total, q, r, vi, ai, oi, cyc, lasts, bad_at, bad_act, bad_exp, lastbad;
    bit stall_seen;
    m = 8 * g;
    total = ((12 * g + n - 1) / n) * n;
    for (int k = 0; k < g; k++) begin
      for (int j = 0; j < 8; j++) exp_q[12*k+j]   = vbit(8*k+j);
      for (int j = 0; j < 4; j++) exp_q[12*k+8+j] = abit(4*k+j);
    end
    r = total - 12 * g;
    q = r / 4;
    for (int p = 0; p < r; p++)
      exp_q[12*g+p] = (p < q) || (p >= 2*q && p < 3*q);
    vi = 0; ai = 0; oi = 0; cyc = 0; lasts = 0; lastbad = 0; bad_at = -1;
    bad_act = 0; bad_exp = 0; stall_seen = 0;
    @(negedge clk_i);
    col_len_i = LEN_W'(n);
    while (oi < total && cyc < 3000) begin
      @(negedge clk_i);
      vid_valid_i = vi < m;
      vid_bit_i   = vbit(vi);
      vid_last_i  = vi == m - 1;
      aud_valid_i = (ai < 4 * g) && (cyc >= aud_block);
      aud_bit_i   = abit(ai);
      lfsr        = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready_i = bp ? (lfsr[0] | lfsr[1]) : 1'b1;
      #1;
      if (aud_block > 0 && cyc == aud_block - 1) begin
        // R6: starved audio must freeze everything after the first 8 video bits
        check(oi == 8 && vi == 8 && !out_valid_o, "R6 stall", oi * 100 + vi, 808);
      end
      if (!out_ready_i && !stall_seen) begin
        stall_seen = 1;
        check(!vid_ready_o && !aud_ready_o, "R8 no take", vid_ready_o + aud_ready_o, 0);
      end
      if (vid_valid_i && vid_ready_o) vi++;
      if (aud_valid_i && aud_ready_o) ai++;
      if (out_valid_o && out_ready_i) begin
        if (out_bit_o != exp_q[oi] && bad_at < 0) begin
          bad_at = oi; bad_act = out_bit_o; bad_exp = exp_q[oi];
        end
        if (out_last_o) lasts++;
        if (out_last_o != (oi == total - 1)) lastbad++;
        oi++;
      end
      cyc++;
    end
    @(negedge clk_i);
    vid_valid_i = 0; aud_valid_i = 0; vid_last_i = 0; out_ready_i = 1;
    #1;
    // R1 covers data bits, R4/R5 the padding span
    if (bad_at >= 12 * g)
      check(1'b0, $sformatf("R4/R5 pad bit %0d (g=%0d n=%0d)", bad_at, g, n), bad_act, bad_exp);
    else
      check(bad_at < 0, $sformatf("R1 data bit %0d (g=%0d n=%0d)", bad_at, g, n), bad_act, bad_exp);
    check(oi == total && !out_valid_o, $sformatf("R2/R3 length g=%0d n=%0d", g, n), oi, total);
    check(lasts == 1 && lastbad == 0, $sformatf("R7 last g=%0d n=%0d", g, n), lasts, 1);
  endtask

  initial begin
    #1;
    check(!out_valid_o && !out_last_o && !aud_ready_o, "R9 reset outputs",
          out_valid_o + out_last_o + aud_ready_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    check(vid_ready_o && !aud_ready_o && !out_valid_o, "R9 first slot video",
          vid_ready_o * 10 + aud_ready_o, 10);
    for (int g = 1; g <= 4; g++)
      for (int n = 1; n <= 13; n++)
        run_frame(g, n, 1'((g + n) & 1), 0);
    run_frame(2, 5, 1'b0, 30);
    run_frame(3, 7, 1'b1, 0);
    finish_run();
  end
endmodule